// File: doc/BRIEF.md
# Frequency/Voltage Code Change Issuer

This block makes one change to the operating point of a clock/voltage control interface and confirms that the change took effect. A single-cycle start pulse carries a type select and a target code. The type select picks either a frequency code or a voltage code. The block first checks that the target fits its field. It then builds a control word that carries the new code and the current value of the other field, and writes that word to the control interface.

After each write the block polls the status input until the change-pending flag drops. If the flag stays high for too long, the block writes the word again. Once the status is quiet, it captures the reported frequency and voltage codes. It then waits a settling time that depends on the type of change, and finishes with a one-cycle done pulse and an error code.

The block handles a single step. The caller decides which steps to take and in what order.

Top module: `fidvid_cmd_issuer`

## Requirements
- R1: While reset is held, and after reset is released, `busy`, `done`, `ctlWrite` and `err` are 0 and `errCode` is 0.
- R2: The lower control word has the frequency code in bits [5:0], the voltage code in bits [12:8] and bit 16 set. All other bits are 0. `ctlWrite` is high for exactly one cycle per write.
- R3: A frequency change (`selVolt`=0) carries the voltage code sampled from status in the start cycle. A voltage change (`selVolt`=1) carries the frequency code sampled in the start cycle.
- R4: The upper control word equals `pllLock`×PLL_CONV (default 5) for a frequency change, and STOP_GRANT (default 1) for a voltage change.
- R5: A target with any bit set above the selected field width (6 bits for frequency, 5 bits for voltage) produces `done` in the first cycle after start. No write is made, and `errCode` = 1.
- R6: Status is sampled on every cycle after a write. A poll attempt succeeds on the first sample with pending low. It fails when POLL_LIMIT+1 consecutive samples show pending high; POLL_LIMIT+1 is therefore the first pending count that fails.
- R7: A failed poll rewrites the same word in the next cycle. When the poll after write number RETRY_LIMIT+1 also fails, the block finishes with `errCode` = 2 and makes no further write.
- R8: After a successful frequency poll, the block waits 10×2^`irtCfg`×CYC_PER_US cycles before `done`.
- R9: After a successful voltage poll, the block waits `vstCfg`×20×CYC_PER_US cycles before `done`. A value of 0 means no wait.
- R10: The captured status decides the result. If the field that was not written differs from its start-cycle value, `errCode` = 4; this case takes priority. Otherwise, if the written field differs from the target, `errCode` = 3. Otherwise `errCode` = 0. `err` is high whenever `errCode` is non-zero.
- R11: `done` is a one-cycle pulse. For a write in cycle w that is followed by P pending samples (P ≤ POLL_LIMIT) and a settling time of D cycles, `done` rises in cycle w+2+P+D, counted from the start-sampling edge. A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle request; accepted only when idle |
| selVolt | input | 1 | 0 = frequency code change, 1 = voltage code change |
| target | input | TGT_W | Requested code |
| pllLock | input | PLL_W | PLL lock time used for the upper word of a frequency write |
| irtCfg | input | 2 | Exponent of the frequency settling time |
| vstCfg | input | VST_W | Voltage settling time in 20 µs units |
| statPending | input | 1 | Status: change still pending |
| statFid | input | FID_W | Status: current frequency code |
| statVid | input | VID_W | Status: current voltage code |
| ctlWrite | output | 1 | Write strobe for the control word |
| ctlLow | output | CW | Lower control word |
| ctlHigh | output | CW | Upper control word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion carries an error |
| errCode | output | 3 | 0 ok, 1 range, 2 stuck pending, 3 target missed, 4 other field moved |

## Verification
The embedded properties check the following on every cycle:
- every write carries the init bit;
- a frequency write keeps the voltage code it snapshotted, and a voltage write keeps the frequency code;
- a range rejection never coincides with a write;
- each write lasts one cycle, and `done` lasts one cycle;
- the poll and rewrite counters never pass their limits.

Only the bench scenarios can show the rest:
- the exact cycle on which each write and `done` happen under different pending lengths, including the poll-limit boundary and the rewrite path;
- that settling times follow `irtCfg` and `vstCfg`;
- which error code results when the status model fails to apply the written field or disturbs the other one.

// File: rtl/fidvid_pkg.sv
package fidvid_pkg;

  // Result reported with done
  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_RANGE  = 3'd1,
    ERR_STUCK  = 3'd2,
    ERR_TARGET = 3'd3,
    ERR_OTHER  = 3'd4
  } errCode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_POLL,
    ST_SETTLE,
    ST_FIN
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // latch command, configuration and status snapshot
    logic markRange;  // target rejected (comes with load)
    logic capture;    // status quiet: judge the reported fields
    logic markStuck;  // rewrites exhausted
  } strobe_t;

endpackage

// File: rtl/fidvid_ctrl.sv
module fidvid_ctrl
  import fidvid_pkg::*;
#(
  parameter int unsigned POLL_LIMIT  = 10000,
  parameter int unsigned RETRY_LIMIT = 100,
  parameter int unsigned DLY_W       = 19
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             rangeBad,
  input  logic             statPending,
  input  logic [DLY_W-1:0] settleCycles,
  output strobe_t          stb,
  output logic             ctlWrite,
  output logic             busy,
  output logic             done
);

  localparam int unsigned PC_W = $clog2(POLL_LIMIT + 1) + 1;
  localparam int unsigned WC_W = $clog2(RETRY_LIMIT + 2) + 1;

  state_e           state, stateNx;
  logic [PC_W-1:0]  pollCnt;
  logic [WC_W-1:0]  writeCnt;
  logic [DLY_W-1:0] settleCnt;
  logic             pollExhausted;
  logic             lastWrite;

  assign pollExhausted = statPending && (pollCnt == PC_W'(POLL_LIMIT));
  assign lastWrite     = (writeCnt == WC_W'(RETRY_LIMIT + 1));

  always_comb begin
    stb     = '0;
    stateNx = state;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          stb.load = 1'b1;
          if (rangeBad) begin
            stb.markRange = 1'b1;
            stateNx       = ST_FIN;
          end else begin
            stateNx = ST_WRITE;
          end
        end
      end
      ST_WRITE: stateNx = ST_POLL;
      ST_POLL: begin
        if (!statPending) begin
          stb.capture = 1'b1;
          stateNx     = (settleCycles == '0) ? ST_FIN : ST_SETTLE;
        end else if (pollExhausted) begin
          if (lastWrite) begin
            stb.markStuck = 1'b1;
            stateNx       = ST_FIN;
          end else begin
            stateNx = ST_WRITE;
          end
        end
      end
      ST_SETTLE: if (settleCnt == DLY_W'(1)) stateNx = ST_FIN;
      ST_FIN:    stateNx = ST_IDLE;
      default:   stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pollCnt   <= '0;
      writeCnt  <= '0;
      settleCnt <= '0;
    end else begin
      state <= stateNx;
      if (stb.load) writeCnt <= '0;
      if (state == ST_WRITE) begin
        writeCnt <= writeCnt + WC_W'(1);
        pollCnt  <= '0;
      end
      if (state == ST_POLL && statPending && !pollExhausted)
        pollCnt <= pollCnt + PC_W'(1);
      if (stb.capture)
        settleCnt <= settleCycles;
      else if (state == ST_SETTLE)
        settleCnt <= settleCnt - DLY_W'(1);
    end
  end

  assign ctlWrite = (state == ST_WRITE);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);

  AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) ctlWrite |=> !ctlWrite);  // R2
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN) pollCnt <= PC_W'(POLL_LIMIT));  // R6
  AST_WRITE_BOUND: assert property (@(posedge clk) disable iff (!rstN) writeCnt <= WC_W'(RETRY_LIMIT + 1));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);  // R11

endmodule

// File: rtl/fidvid_dpath.sv
module fidvid_dpath
  import fidvid_pkg::*;
#(
  parameter int unsigned FID_W      = 6,
  parameter int unsigned VID_W      = 5,
  parameter int unsigned TGT_W      = 8,
  parameter int unsigned VID_SH     = 8,
  parameter int unsigned INIT_BIT   = 16,
  parameter int unsigned CW         = 32,
  parameter int unsigned PLL_W      = 8,
  parameter int unsigned PLL_CONV   = 5,
  parameter int unsigned STOP_GRANT = 1,
  parameter int unsigned VST_W      = 8,
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned DLY_W      = 19
)(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             wrActive,
  input  logic             selVolt,
  input  logic [TGT_W-1:0] target,
  input  logic [PLL_W-1:0] pllLock,
  input  logic [1:0]       irtCfg,
  input  logic [VST_W-1:0] vstCfg,
  input  logic [FID_W-1:0] statFid,
  input  logic [VID_W-1:0] statVid,
  output logic             rangeBad,
  output logic [DLY_W-1:0] settleCycles,
  output logic [CW-1:0]    ctlLow,
  output logic [CW-1:0]    ctlHigh,
  output errCode_e         errCode
);

  localparam logic [TGT_W-1:0] FID_MASK  = TGT_W'((1 << FID_W) - 1);
  localparam logic [TGT_W-1:0] VID_MASK  = TGT_W'((1 << VID_W) - 1);
  localparam int unsigned      FREQ_BASE = 10 * CYC_PER_US;
  localparam int unsigned      VST_UNIT  = 20 * CYC_PER_US;

  logic             selLat;
  logic [TGT_W-1:0] tgtLat;
  logic [FID_W-1:0] snapFid;
  logic [VID_W-1:0] snapVid;
  logic [PLL_W-1:0] pllLat;
  logic [1:0]       irtLat;
  logic [VST_W-1:0] vstLat;
  logic [FID_W-1:0] fidField;
  logic [VID_W-1:0] vidField;
  logic [CW-1:0]    pllWord;
  logic             writtenOk;
  logic             otherOk;
  errCode_e         verdict;

  // Reject targets with bits outside the selected field
  assign rangeBad = selVolt ? |(target & ~VID_MASK) : |(target & ~FID_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selLat  <= 1'b0;
      tgtLat  <= '0;
      snapFid <= '0;
      snapVid <= '0;
      pllLat  <= '0;
      irtLat  <= '0;
      vstLat  <= '0;
      errCode <= ERR_NONE;
    end else begin
      if (stb.load) begin
        selLat  <= selVolt;
        tgtLat  <= target;
        snapFid <= statFid;
        snapVid <= statVid;
        pllLat  <= pllLock;
        irtLat  <= irtCfg;
        vstLat  <= vstCfg;
        errCode <= stb.markRange ? ERR_RANGE : ERR_NONE;
      end else if (stb.markStuck) begin
        errCode <= ERR_STUCK;
      end else if (stb.capture) begin
        errCode <= verdict;
      end
    end
  end

  // Control word: new code in its field, the other field held from the snapshot
  assign fidField = selLat ? snapFid : tgtLat[FID_W-1:0];
  assign vidField = selLat ? tgtLat[VID_W-1:0] : snapVid;
  assign ctlLow   = CW'(fidField) | (CW'(vidField) << VID_SH) | (CW'(1) << INIT_BIT);

  if (PLL_CONV == 1) begin : g_pllDirect
    assign pllWord = CW'(pllLat);
  end else begin : g_pllScaled
    assign pllWord = CW'(pllLat) * CW'(PLL_CONV);
  end
  assign ctlHigh = selLat ? CW'(STOP_GRANT) : pllWord;

  // Settling time in cycles, by type of change
  assign settleCycles = selLat ? (DLY_W'(vstLat) * DLY_W'(VST_UNIT))
                               : (DLY_W'(FREQ_BASE) << irtLat);

  // Judge the status captured once pending has dropped
  assign writtenOk = selLat ? (statVid == tgtLat[VID_W-1:0]) : (statFid == tgtLat[FID_W-1:0]);
  assign otherOk   = selLat ? (statFid == snapFid) : (statVid == snapVid);

  always_comb begin
    if (!otherOk)        verdict = ERR_OTHER;
    else if (!writtenOk) verdict = ERR_TARGET;
    else                 verdict = ERR_NONE;
  end

  AST_INIT_SET: assert property (@(posedge clk) disable iff (!rstN) wrActive |-> ctlLow[INIT_BIT]);  // R2
  AST_KEEP_VID: assert property (@(posedge clk) disable iff (!rstN) (wrActive && !selLat) |-> (ctlLow[VID_SH +: VID_W] == snapVid));  // R3
  AST_KEEP_FID: assert property (@(posedge clk) disable iff (!rstN) (wrActive && selLat) |-> (ctlLow[FID_W-1:0] == snapFid));  // R3
  AST_RANGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) (errCode == ERR_RANGE) |-> !wrActive);  // R5

endmodule

// File: rtl/fidvid_cmd_issuer.sv
module fidvid_cmd_issuer
  import fidvid_pkg::*;
#(
  parameter int unsigned FID_W       = 6,
  parameter int unsigned VID_W       = 5,
  parameter int unsigned TGT_W       = 8,
  parameter int unsigned VID_SH      = 8,
  parameter int unsigned INIT_BIT    = 16,
  parameter int unsigned CW          = 32,
  parameter int unsigned PLL_W       = 8,
  parameter int unsigned PLL_CONV    = 5,
  parameter int unsigned STOP_GRANT  = 1,
  parameter int unsigned VST_W       = 8,
  parameter int unsigned CYC_PER_US  = 100,
  parameter int unsigned POLL_LIMIT  = 10000,
  parameter int unsigned RETRY_LIMIT = 100
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             selVolt,
  input  logic [TGT_W-1:0] target,
  input  logic [PLL_W-1:0] pllLock,
  input  logic [1:0]       irtCfg,
  input  logic [VST_W-1:0] vstCfg,
  input  logic             statPending,
  input  logic [FID_W-1:0] statFid,
  input  logic [VID_W-1:0] statVid,
  output logic             ctlWrite,
  output logic [CW-1:0]    ctlLow,
  output logic [CW-1:0]    ctlHigh,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       errCode
);

  localparam int unsigned FREQ_MAX = 80;
  localparam int unsigned VOLT_MAX = 20 * ((1 << VST_W) - 1);
  localparam int unsigned MAX_DLY  = ((FREQ_MAX > VOLT_MAX) ? FREQ_MAX : VOLT_MAX) * CYC_PER_US;
  localparam int unsigned DLY_W    = $clog2(MAX_DLY + 1);

  strobe_t          stb;
  logic             rangeBad;
  logic [DLY_W-1:0] settleCycles;
  errCode_e         errCodeE;

  fidvid_ctrl #(
    .POLL_LIMIT (POLL_LIMIT),
    .RETRY_LIMIT(RETRY_LIMIT),
    .DLY_W      (DLY_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .rangeBad    (rangeBad),
    .statPending (statPending),
    .settleCycles(settleCycles),
    .stb         (stb),
    .ctlWrite    (ctlWrite),
    .busy        (busy),
    .done        (done)
  );

  fidvid_dpath #(
    .FID_W     (FID_W),
    .VID_W     (VID_W),
    .TGT_W     (TGT_W),
    .VID_SH    (VID_SH),
    .INIT_BIT  (INIT_BIT),
    .CW        (CW),
    .PLL_W     (PLL_W),
    .PLL_CONV  (PLL_CONV),
    .STOP_GRANT(STOP_GRANT),
    .VST_W     (VST_W),
    .CYC_PER_US(CYC_PER_US),
    .DLY_W     (DLY_W)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrActive    (ctlWrite),
    .selVolt     (selVolt),
    .target      (target),
    .pllLock     (pllLock),
    .irtCfg      (irtCfg),
    .vstCfg      (vstCfg),
    .statFid     (statFid),
    .statVid     (statVid),
    .rangeBad    (rangeBad),
    .settleCycles(settleCycles),
    .ctlLow      (ctlLow),
    .ctlHigh     (ctlHigh),
    .errCode     (errCodeE)
  );

  assign errCode = errCodeE;
  assign err     = (errCodeE != ERR_NONE);

endmodule

// File: tb/fidvid_cmd_issuer_tb_top.sv
module fidvid_cmd_issuer_tb_top;

  localparam int CPU = 2;
  localparam int PL  = 6;
  localparam int RL  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        selVolt = 1'b0;
  logic [7:0]  target = '0;
  logic [7:0]  pllLock = 8'd20;
  logic [1:0]  irtCfg = 2'd1;
  logic [7:0]  vstCfg = 8'd2;
  logic        statPending;
  logic [5:0]  statFid;
  logic [4:0]  statVid;
  logic        ctlWrite;
  logic [31:0] ctlLow, ctlHigh;
  logic        busy, done, err;
  logic [2:0]  errCode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // status model state
  int         pendQ[$];
  int         planQ[$];
  int         pendLeft = 0;
  int         faultMode = 0;
  bit         modelSel = 1'b0;
  logic [5:0] curFid = 6'h0C;
  logic [4:0] curVid = 5'h10;
  logic [5:0] wF;
  logic [4:0] wV;

  always #5 clk = ~clk;

  fidvid_cmd_issuer #(
    .CYC_PER_US (CPU),
    .POLL_LIMIT (PL),
    .RETRY_LIMIT(RL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .selVolt(selVolt),
    .target(target), .pllLock(pllLock), .irtCfg(irtCfg), .vstCfg(vstCfg),
    .statPending(statPending), .statFid(statFid), .statVid(statVid),
    .ctlWrite(ctlWrite), .ctlLow(ctlLow), .ctlHigh(ctlHigh),
    .busy(busy), .done(done), .err(err), .errCode(errCode)
  );

  assign statPending = (pendLeft > 0);
  assign statFid     = curFid;
  assign statVid     = curVid;

  // Behavioural power-control interface
  always @(posedge clk) begin
    if (ctlWrite) begin
      if (pendQ.size() > 0) pendLeft <= pendQ.pop_front();
      else pendLeft <= 0;
      wF = ctlLow[5:0];
      wV = ctlLow[12:8];
      if (faultMode[1]) begin
        if (modelSel) wV = curVid; else wF = curFid;
      end
      if (faultMode[0]) begin
        if (modelSel) wF = wF ^ 6'd1; else wV = wV ^ 5'd1;
      end
      curFid <= wF;
      curVid <= wV;
    end else if (pendLeft > 0) begin
      pendLeft <= pendLeft - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // Issues one command and compares the outputs on every cycle against the schedule
  task automatic runCmd(input bit vSel, input logic [7:0] tgt, input int expCode,
                        input int pokeAt, input string req);
    int writeWin[$];
    int doneWin;
    int dly;
    int t;
    bit bad;
    logic [31:0] expLow, expHigh;
    bad     = vSel ? (tgt >= 8'd32) : (tgt >= 8'd64);
    dly     = vSel ? int'(vstCfg) * 20 * CPU : 10 * (1 << irtCfg) * CPU;
    expLow  = vSel ? (32'(curFid) | (32'(tgt) << 8) | 32'h10000)
                   : (32'(tgt) | (32'(curVid) << 8) | 32'h10000);
    expHigh = vSel ? 32'd1 : 32'(pllLock) * 32'd5;
    doneWin = 1;
    if (!bad) begin
      t = 1;
      for (int i = 0; i <= RL; i++) begin
        int p;
        p = (i < planQ.size()) ? planQ[i] : 0;
        writeWin.push_back(t);
        if (p <= PL) begin doneWin = t + 2 + p + dly; break; end
        if (i == RL) begin doneWin = t + 2 + PL; break; end
        t = t + 2 + PL;
      end
    end
    pendQ    = planQ;
    modelSel = vSel;
    @(negedge clk);
    startPulse = 1'b1; selVolt = vSel; target = tgt;
    @(negedge clk);
    startPulse = 1'b0;
    for (int w = 1; w <= doneWin; w++) begin
      bit ew;
      if (w > 1) @(negedge clk);
      ew = 1'b0;
      foreach (writeWin[k]) if (writeWin[k] == w) ew = 1'b1;
      chk(ctlWrite == ew, req, $sformatf("ctlWrite cycle %0d", w), ctlWrite, ew);
      chk(done == (w == doneWin), "R11", $sformatf("done cycle %0d", w), done, (w == doneWin));
      chk(busy == 1'b1, "R11", "busy during command", busy, 1);
      if (ew) begin
        chk(ctlLow == expLow, "R2", "lower control word", ctlLow, expLow);
        chk(ctlHigh == expHigh, "R4", "upper control word", ctlHigh, expHigh);
      end
      if (w == doneWin) begin
        chk(errCode == 3'(expCode), req, "errCode", errCode, expCode);
        chk(err == (expCode != 0), "R10", "err flag", err, (expCode != 0));
      end
      if (w == pokeAt) begin
        startPulse = 1'b1; target = tgt ^ 8'd1;
      end else begin
        startPulse = 1'b0;
      end
    end
    @(negedge clk);
    startPulse = 1'b0;
    chk(!busy && !done, "R11", "idle after done", {busy, done}, 0);
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ctlWrite && !err && errCode == 0, "R1", "outputs in reset",
        {busy, done, ctlWrite, err, errCode}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !ctlWrite && !err && errCode == 0, "R1", "outputs after reset",
        {busy, done, ctlWrite, err, errCode}, 0);

    // R8 frequency change, short pending; start poke during settle ignored (R11)
    planQ = '{3}; runCmd(1'b0, 8'h12, 0, 20, "R8");
    // R9 voltage change, no pending
    planQ = '{0}; runCmd(1'b1, 8'h0A, 0, 0, "R9");
    // R6 boundary: pending for exactly POLL_LIMIT samples still succeeds
    irtCfg = 2'd3; pllLock = 8'd7;
    planQ = '{PL}; runCmd(1'b0, 8'h20, 0, 0, "R6");
    // R9 zero voltage settle
    vstCfg = 8'd0;
    planQ = '{1}; runCmd(1'b1, 8'h03, 0, 0, "R9");
    // R5 range rejection, both types
    planQ = '{}; runCmd(1'b0, 8'h40, 1, 0, "R5");
    planQ = '{}; runCmd(1'b1, 8'h20, 1, 0, "R5");
    // R7 one rewrite then success (first poll exceeds the limit by one)
    irtCfg = 2'd0; vstCfg = 8'd1;
    planQ = '{PL + 1, 2}; runCmd(1'b0, 8'h15, 0, 0, "R7");
    // R7 stuck pending on every write
    planQ = '{9, 9, 9}; runCmd(1'b1, 8'h07, 2, 0, "R7");
    // R10 other field disturbed on a frequency write
    faultMode = 1; planQ = '{2}; runCmd(1'b0, 8'h18, 4, 0, "R10");
    // R10 written field not applied on a voltage write
    faultMode = 2; planQ = '{1}; runCmd(1'b1, 8'h0F, 3, 0, "R10");
    // R10 both faults: other-field error takes priority
    faultMode = 3; planQ = '{0}; runCmd(1'b0, 8'h1E, 4, 0, "R10");
    faultMode = 0;
    // R3 keep-other after faults moved the status fields
    planQ = '{2}; runCmd(1'b1, 8'h11, 0, 0, "R3");
    planQ = '{2}; runCmd(1'b0, 8'h2A, 0, 0, "R3");

    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      report();
    end
  end

endmodule